// File: doc/BRIEF.md
# Tach Measurement Byte-Pair Read Port

This block exposes four live 16-bit fan tachometer counts to a byte-wide register read port. Each count occupies two consecutive 8-bit addresses: the low byte at the even address and the high byte at the odd address above it. The four pairs fill the window 28h to 2Fh, with channel 0 at 28h/29h and channel 3 at 2Eh/2Fh. The counts keep changing while software reads them. A plain byte-by-byte read could therefore mix the low half of one measurement with the high half of a later one.

To prevent this, a read of a channel's low byte takes one snapshot of that channel's count. The low byte is returned from the snapshot, and its high byte is parked in a per-channel hold register. The next read of that channel's high byte returns the parked value and releases the hold. After that, high-byte reads follow the live count again, and no further low-byte read is needed. Channels are fully independent. Addresses outside the window read as zero and change no state.

Top module: `tach_split_reader`

## Requirements
- R1: One clock after a read strobe at a channel's even address (28h + 2*ch), `rd_data` equals bits [7:0] of that channel's live count as sampled at the strobe edge.
- R2: After a low-byte read of a channel, the next high-byte read of that channel (29h + 2*ch) returns bits [15:8] of the count sampled at the low-byte read, even if the live count changed in between.
- R3: A high-byte read releases the hold, so a later high-byte read of the same channel returns bits [15:8] of the live count at that later strobe.
- R4: A high-byte read of a channel with no hold pending returns bits [15:8] of the live count at the strobe edge, one clock later.
- R5: Reads of one channel never change what another channel's high byte returns.
- R6: A low-byte read while that channel's high byte is already held replaces the held byte with a fresh snapshot.
- R7: A read at any address outside 28h..2Fh yields `rd_data` = 00h one clock later and leaves every hold unchanged.
- R8: With `rst` high at a clock edge, `rd_data` becomes 00h and all holds are cleared, so high-byte reads after reset return live data.
- R9: While `rd_en` is low, `rd_data` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| rd_en | input | 1 | Read strobe, one read per cycle it is high |
| rd_addr | input | 8 | Byte address of the read |
| tach_live | input | 64 | Four live 16-bit counts, channel ch at bits [16*ch+15:16*ch] |
| rd_data | output | 8 | Registered read data, valid the clock after the strobe |

## Verification
The assertions assume that `tach_live`, `rd_en` and `rd_addr` are stable around each rising edge. They also assume that a channel's count is only meaningful in the cycle it is sampled, so a back-to-back low-then-high read pair can be checked against the count from two edges earlier. The stimulus changes inputs only on falling edges. It changes the live counts between the two halves of a read pair to expose any loss of the snapshot. It uses adjacent, low, high and far-out-of-window addresses to probe the edges of the decode.

// File: rtl/tach_rd_pkg.sv
package tach_rd_pkg;
    parameter int NUM_CH = 4;
    parameter int BYTE_W = 8;
    parameter int ADDR_W = 8;
    parameter logic [ADDR_W-1:0] WIN_BASE = 8'h28;

    localparam int TACH_W = 2 * BYTE_W;
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int WIN_SZ = 2 * NUM_CH;

    typedef logic [CH_W-1:0]   ch_idx_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_LOW  = 2'd1,
        ACC_HIGH = 2'd2
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e kind;
        ch_idx_t   ch;
    } rd_req_t;

    function automatic rd_req_t decode_rd(input logic en, input logic [ADDR_W-1:0] addr);
        rd_req_t r;
        logic [ADDR_W-1:0] ofs;
        ofs    = addr - WIN_BASE;
        r.kind = ACC_NONE;
        r.ch   = '0;
        if (en && (addr >= WIN_BASE) && (ofs < ADDR_W'(WIN_SZ))) begin
            r.kind = ofs[0] ? ACC_HIGH : ACC_LOW;
            r.ch   = ofs[CH_W:1];
        end
        return r;
    endfunction
endpackage

// File: rtl/tach_req_decode.sv
module tach_req_decode
    import tach_rd_pkg::*;
(
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output rd_req_t           req,
    output logic [NUM_CH-1:0] cap_vec,
    output logic [NUM_CH-1:0] rel_vec
);
    always_comb begin
        req = decode_rd(rd_en, rd_addr);
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_sel
        assign cap_vec[g] = (req.kind == ACC_LOW)  && (req.ch == ch_idx_t'(g));
        assign rel_vec[g] = (req.kind == ACC_HIGH) && (req.ch == ch_idx_t'(g));
    end
endmodule

// File: rtl/tach_hold_lane.sv
module tach_hold_lane
    import tach_rd_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cap,
    input  logic  rel,
    input  byte_t live_hi,
    output byte_t hi_view
);
    logic  held_q;
    byte_t park_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= 1'b0;
            park_q <= '0;
        end else if (cap) begin
            held_q <= 1'b1;
            park_q <= live_hi;
        end else if (rel) begin
            held_q <= 1'b0;
        end
    end

    assign hi_view = held_q ? park_q : live_hi;
endmodule

// File: rtl/tach_split_reader.sv
module tach_split_reader
    import tach_rd_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     rd_en,
    input  logic [ADDR_W-1:0]        rd_addr,
    input  logic [NUM_CH*TACH_W-1:0] tach_live,
    output logic [BYTE_W-1:0]        rd_data
);
    rd_req_t           req;
    logic [NUM_CH-1:0] cap_vec;
    logic [NUM_CH-1:0] rel_vec;
    byte_t             lo_live [NUM_CH];
    byte_t             hi_view [NUM_CH];
    byte_t             next_byte;

    tach_req_decode u_dec (
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .req     (req),
        .cap_vec (cap_vec),
        .rel_vec (rel_vec)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
        assign lo_live[g] = tach_live[g*TACH_W +: BYTE_W];

        tach_hold_lane u_lane (
            .clk     (clk),
            .rst     (rst),
            .cap     (cap_vec[g]),
            .rel     (rel_vec[g]),
            .live_hi (tach_live[g*TACH_W+BYTE_W +: BYTE_W]),
            .hi_view (hi_view[g])
        );
    end

    always_comb begin
        unique case (req.kind)
            ACC_LOW:  next_byte = lo_live[req.ch];
            ACC_HIGH: next_byte = hi_view[req.ch];
            default:  next_byte = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= next_byte;
        end
    end
endmodule

// File: rtl/tach_split_reader_chk.sv
module tach_split_reader_chk
    import tach_rd_pkg::*;
(
    input logic                     clk,
    input logic                     rst,
    input logic                     rd_en,
    input logic [ADDR_W-1:0]        rd_addr,
    input logic [NUM_CH*TACH_W-1:0] tach_live,
    input logic [BYTE_W-1:0]        rd_data
);
    rd_req_t c_req;
    byte_t   c_lo;
    byte_t   c_hi;
    logic    c_low;
    logic    c_high;
    logic    c_miss;

    always_comb begin
        c_req  = decode_rd(rd_en, rd_addr);
        c_lo   = tach_live[c_req.ch*TACH_W +: BYTE_W];
        c_hi   = tach_live[c_req.ch*TACH_W+BYTE_W +: BYTE_W];
        c_low  = (c_req.kind == ACC_LOW);
        c_high = (c_req.kind == ACC_HIGH);
        c_miss = rd_en && (c_req.kind == ACC_NONE);
    end

    AST_LOW_LIVE: assert property (@(posedge clk) disable iff (rst)
        c_low |=> rd_data == $past(c_lo)); // R1

    AST_PAIR_SNAPSHOT: assert property (@(posedge clk) disable iff (rst)
        c_low ##1 (c_high && c_req.ch == $past(c_req.ch)) |=> rd_data == $past(c_hi, 2)); // R2

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        c_miss |=> rd_data == '0); // R7

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> rd_data == '0); // R8

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        !rd_en && !$past(rst) |=> $stable(rd_data)); // R9
endmodule

bind tach_split_reader tach_split_reader_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .tach_live (tach_live),
    .rd_data   (rd_data)
);

// File: tb/test_tach_split_reader.sv
module test_tach_split_reader;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_addr = 8'h00;
    logic [15:0] live [4];
    logic [63:0] tach_live;
    logic [7:0]  rd_data;

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0] exp_q [$];
    string      tag_q [$];

    logic       m_held [4];
    logic [7:0] m_park [4];

    always #10 clk = ~clk;

    assign tach_live = {live[3], live[2], live[1], live[0]};

    tach_split_reader i_tach_split_reader (
        .clk       (clk),
        .rst       (rst),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .tach_live (tach_live),
        .rd_data   (rd_data)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: rd_data=%02h expected=%02h", tag, act, exp);
        end
    endtask

    function automatic void model_reset();
        for (int i = 0; i < 4; i++) begin
            m_held[i] = 1'b0;
            m_park[i] = 8'h00;
        end
    endfunction

    // Driver: one strobe cycle, expected value from the requirement model
    task automatic rd(input logic [7:0] a, input string tag);
        logic [7:0] e;
        int ch;
        @(negedge clk);
        rd_en   = 1'b1;
        rd_addr = a;
        if (a >= 8'h28 && a <= 8'h2F) begin
            ch = int'((a - 8'h28) >> 1);
            if (a[0] == 1'b0) begin
                e = live[ch][7:0];
                m_held[ch] = 1'b1;
                m_park[ch] = live[ch][15:8];
            end else begin
                e = m_held[ch] ? m_park[ch] : live[ch][15:8];
                m_held[ch] = 1'b0;
            end
        end else begin
            e = 8'h00;
        end
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // Monitor: pops one expectation per strobe, samples mid-high-phase
    initial begin
        forever begin
            logic fire;
            @(posedge clk);
            fire = rd_en && !rst;
            #5;
            if (fire && exp_q.size() > 0) begin
                check(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    initial begin
        #2_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] keep;
        live[0] = 16'h1234; live[1] = 16'h7788; live[2] = 16'hC3A5; live[3] = 16'hF00F;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R8 reset rd_data", rd_data, 8'h00);

        rd(8'h29, "R8 high after reset is live");
        rd(8'h28, "R1 low byte live");
        @(negedge clk); live[0] = 16'hABCD;
        rd(8'h29, "R2 high from snapshot");
        rd(8'h29, "R3 high after release is live");
        @(negedge clk); live[0] = 16'h5566;
        rd(8'h29, "R4 high without hold");

        rd(8'h2A, "R1 ch1 low");
        @(negedge clk); live[1] = 16'h9900; live[2] = 16'h4411;
        rd(8'h2D, "R5 ch2 high unaffected by ch1 hold");
        rd(8'h2B, "R5 ch1 still held");

        rd(8'h2E, "R1 ch3 low");
        @(negedge clk); live[3] = 16'h1E2E;
        rd(8'h2E, "R6 recapture low");
        @(negedge clk); live[3] = 16'h3344;
        rd(8'h2F, "R6 high from recapture");

        rd(8'h2C, "R1 ch2 low before misses");
        @(negedge clk); live[2] = 16'h0000;
        rd(8'h27, "R7 below window");
        rd(8'h30, "R7 above window");
        rd(8'hFF, "R7 far address");
        rd(8'h2D, "R7 hold survived misses");

        rd(8'h2A, "R1 ch1 low before idle");
        keep = 8'h00 + live[1][7:0];
        repeat (4) begin
            @(negedge clk);
            live[1] = live[1] + 16'h0101;
        end
        #5;
        check("R9 idle keeps rd_data", rd_data, keep);

        rd(8'h2E, "R1 ch3 low before reset");
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        model_reset();
        check("R8 reset clears rd_data", rd_data, 8'h00);
        live[3] = 16'h6A5B;
        rd(8'h2F, "R8 hold cleared by reset");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_chk++; n_bad++;
            $display("FAIL scoreboard: %0d results missing, expected 0", exp_q.size());
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule